// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Detector

This block watches 32 general-purpose input pins and turns activity on them into interrupt requests. Each pin has a 4-bit sense field. The low three bits of the field choose what counts as an event: a rising edge, a falling edge, a high level, a low level, or either edge. A pin can only latch an event when its detection-input enable bit is set. Latched events sit in a raw pending vector until software clears them by writing ones. A separate per-pin mask decides which pending bits reach the two interrupt outputs. One output covers pins 0 to 15 and the other covers pins 16 to 31.

Software reaches the block through a simple synchronous register port with byte addresses. Writes take effect on the clock edge where `regWrEn` is high. Reads are combinational from `regAddr`. The mask has no plain write. Ones written to one address unmask pins, and ones written to a second address mask them. The mask state reads back at the masking address. Pin inputs are asynchronous and pass through a two-stage synchronizer before detection.

Top module: `gpio_irq_top`

## Requirements
- R1: After reset, every pin is masked (address 0x1C reads 0xFFFFFFFF), every detection enable is 0, every sense register reads 0, the raw pending vector reads 0, and both interrupt outputs are low.
- R2: Address 0x14 is a read/write detection-enable vector with bit i for pin i. A pin whose bit is 0 never sets its pending bit, whatever the input does.
- R3: Writing to address 0x18 unmasks (clears the mask bit of) each pin whose data bit is 1. Pins whose data bit is 0 keep their mask state.
- R4: Writing to address 0x1C masks (sets the mask bit of) each pin whose data bit is 1. Reading 0x1C returns the mask vector, where 1 means masked.
- R5: Address 0x20 reads the raw pending vector. Address 0x24 reads pending AND NOT mask.
- R6: Writing to address 0x28 clears each pending bit whose data bit is 1. Bits written as 0 have no effect. A clear and a new event on the same edge leave the bit cleared.
- R7: The sense registers are at 0x40, 0x44, 0x48 and 0x4C. Register n holds the field of pin 8n+k at bits 4k+3..4k, and all four bits read back as written.
- R8: The sense code in bits 2..0 selects the event type: 0 = rising edge, 1 = falling edge, 2 = high level, 3 = low level, 4 = either edge. Codes 5 to 7 detect nothing. Bit 3 (the asynchronous flag) is stored but does not change detection.
- R9: A change on a pin input, applied between clock edges, shows in the raw pending vector after the third following rising clock edge and not before.
- R10: In a level mode, a pending bit cleared while the level is still active sets again on the next clock edge. An edge event that has been cleared stays clear while the input holds steady.
- R11: If the sense mode changes and a clear is then written, an event latched under the old mode is removed and does not return unless the new mode detects an event.
- R12: `irqLow` is the OR of (pending AND NOT mask) over pins 15..0, and `irqHigh` is the same OR over pins 31..16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 8 | Register byte address |
| regWrEn | input | 1 | Write strobe; the write takes effect on this edge |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data for `regAddr` |
| pinIn | input | 32 | Asynchronous pin inputs |
| irqLow | output | 1 | Interrupt request for pins 0 to 15 |
| irqHigh | output | 1 | Interrupt request for pins 16 to 31 |

## Verification
Register writes change state on the edge that samples `regWrEn`, and the read port is combinational. The bench therefore reads back one half-cycle after each write, at the falling edge.

A pin change reaches the pending vector after three rising edges: two synchronizer stages, then the pending register. The bench drives pins at a falling edge and checks both just before and just after the third edge, which pins down the latency in R9.

The interrupt outputs are combinational from pending and mask, so they are checked in the same half-cycle as the register reads. For the level re-set case, the bench samples the cleared bit right after the clear, then again one edge later.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int PIN_COUNT      = 32;
  localparam int FIELD_W        = 4;
  localparam int FIELDS_PER_REG = PIN_COUNT / FIELD_W;
  localparam int SENSE_REGS     = PIN_COUNT / FIELDS_PER_REG;
  localparam int ADDR_W         = 8;

  localparam logic [ADDR_W-1:0] ADDR_DET_EN = 8'h14;
  localparam logic [ADDR_W-1:0] ADDR_UNMASK = 8'h18;
  localparam logic [ADDR_W-1:0] ADDR_MASK   = 8'h1C;
  localparam logic [ADDR_W-1:0] ADDR_RAW    = 8'h20;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 8'h24;
  localparam logic [ADDR_W-1:0] ADDR_CLEAR  = 8'h28;
  localparam logic [ADDR_W-1:0] ADDR_SENSE0 = 8'h40;

  typedef enum logic [2:0] {
    SENSE_RISE  = 3'd0,
    SENSE_FALL  = 3'd1,
    SENSE_HIGH  = 3'd2,
    SENSE_LOW   = 3'd3,
    SENSE_BOTH  = 3'd4
  } senseMode_e;

  typedef struct packed {
    logic                  detEnWr;
    logic                  unmaskSet;
    logic                  maskSet;
    logic                  clearWr;
    logic [SENSE_REGS-1:0] senseWr;
    logic [PIN_COUNT-1:0]  data;
  } ctrlStrobes_t;
endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [ADDR_W-1:0]             regAddr,
  input  logic                          regWrEn,
  input  logic [PIN_COUNT-1:0]          regWrData,
  input  logic [PIN_COUNT-1:0]          detEnQ,
  input  logic [PIN_COUNT-1:0]          maskQ,
  input  logic [PIN_COUNT-1:0]          pendingQ,
  input  logic [PIN_COUNT*FIELD_W-1:0]  senseFlat,
  output ctrlStrobes_t                  strobes,
  output logic [PIN_COUNT-1:0]          regRdData
);
  localparam int REG_BITS = FIELDS_PER_REG * FIELD_W;

  always_comb begin
    strobes.detEnWr   = regWrEn && (regAddr == ADDR_DET_EN);
    strobes.unmaskSet = regWrEn && (regAddr == ADDR_UNMASK);
    strobes.maskSet   = regWrEn && (regAddr == ADDR_MASK);
    strobes.clearWr   = regWrEn && (regAddr == ADDR_CLEAR);
    strobes.data      = regWrData;
    for (int n = 0; n < SENSE_REGS; n++) begin
      strobes.senseWr[n] = regWrEn &&
        (regAddr == ADDR_SENSE0 + ADDR_W'(4 * n));
    end
  end

  always_comb begin
    regRdData = '0;
    unique case (regAddr)
      ADDR_DET_EN: regRdData = detEnQ;
      ADDR_MASK:   regRdData = maskQ;
      ADDR_RAW:    regRdData = pendingQ;
      ADDR_STATUS: regRdData = pendingQ & ~maskQ;
      default: begin
        for (int n = 0; n < SENSE_REGS; n++) begin
          if (regAddr == ADDR_SENSE0 + ADDR_W'(4 * n))
            regRdData = senseFlat[n*REG_BITS +: REG_BITS];
        end
      end
    endcase
  end

  // At most one register target is struck per cycle (R7 decode)
  assert_one_target_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.detEnWr, strobes.unmaskSet, strobes.maskSet,
              strobes.clearWr, strobes.senseWr}));
endmodule

// File: rtl/gpio_irq_datapath.sv
module gpio_irq_datapath
  import gpio_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [PIN_COUNT-1:0]          pinIn,
  input  ctrlStrobes_t                  strobes,
  output logic [PIN_COUNT-1:0]          detEnQ,
  output logic [PIN_COUNT-1:0]          maskQ,
  output logic [PIN_COUNT-1:0]          pendingQ,
  output logic [PIN_COUNT*FIELD_W-1:0]  senseFlat,
  output logic                          irqLow,
  output logic                          irqHigh
);
  localparam int HALF = PIN_COUNT / 2;

  logic [SYNC_STAGES-1:0][PIN_COUNT-1:0] syncQ;
  logic [PIN_COUNT-1:0] pinSync, pinPrev, pinEvent;
  logic [PIN_COUNT-1:0][FIELD_W-1:0] senseQ;
  logic [PIN_COUNT-1:0] activeSt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ   <= '0;
      pinPrev <= '0;
    end else begin
      syncQ[0] <= pinIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      pinPrev <= pinSync;
    end
  end
  assign pinSync = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      senseQ <= '0;
    end else begin
      for (int n = 0; n < SENSE_REGS; n++) begin
        if (strobes.senseWr[n]) begin
          for (int k = 0; k < FIELDS_PER_REG; k++)
            senseQ[n*FIELDS_PER_REG + k] <= strobes.data[k*FIELD_W +: FIELD_W];
        end
      end
    end
  end
  assign senseFlat = senseQ;

  for (genvar i = 0; i < PIN_COUNT; i++) begin : g_detect
    always_comb begin
      unique case (senseQ[i][2:0])
        SENSE_RISE: pinEvent[i] = pinSync[i] & ~pinPrev[i];
        SENSE_FALL: pinEvent[i] = ~pinSync[i] & pinPrev[i];
        SENSE_HIGH: pinEvent[i] = pinSync[i];
        SENSE_LOW:  pinEvent[i] = ~pinSync[i];
        SENSE_BOTH: pinEvent[i] = pinSync[i] ^ pinPrev[i];
        default:    pinEvent[i] = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      detEnQ   <= '0;
      maskQ    <= '1;
      pendingQ <= '0;
    end else begin
      if (strobes.detEnWr)   detEnQ <= strobes.data;
      if (strobes.unmaskSet) maskQ  <= maskQ & ~strobes.data;
      else if (strobes.maskSet) maskQ <= maskQ | strobes.data;
      pendingQ <= (pendingQ | (pinEvent & detEnQ)) &
                  ~(strobes.clearWr ? strobes.data : '0);
    end
  end

  assign activeSt = pendingQ & ~maskQ;
  assign irqLow   = |activeSt[HALF-1:0];
  assign irqHigh  = |activeSt[PIN_COUNT-1:HALF];

  assert_disabled_no_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    ((pendingQ & ~$past(pendingQ) & ~$past(detEnQ)) == '0));

  assert_unmask_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.unmaskSet |=> ((maskQ & $past(strobes.data)) == '0));

  assert_mask_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.maskSet |=> ((maskQ & $past(strobes.data)) == $past(strobes.data)));

  assert_clear_wins_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearWr |=> ((pendingQ & $past(strobes.data)) == '0));

  assert_masked_quiet_R12: assert property (@(posedge clk) disable iff (!rstN)
    (&maskQ) |-> !(irqLow || irqHigh));
endmodule

// File: rtl/gpio_irq_top.sv
module gpio_irq_top
  import gpio_irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWrEn,
  input  logic [PIN_COUNT-1:0] regWrData,
  output logic [PIN_COUNT-1:0] regRdData,
  input  logic [PIN_COUNT-1:0] pinIn,
  output logic                 irqLow,
  output logic                 irqHigh
);
  ctrlStrobes_t strobes;
  logic [PIN_COUNT-1:0] detEnQ, maskQ, pendingQ;
  logic [PIN_COUNT*FIELD_W-1:0] senseFlat;

  gpio_irq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .detEnQ(detEnQ), .maskQ(maskQ),
    .pendingQ(pendingQ), .senseFlat(senseFlat), .strobes(strobes),
    .regRdData(regRdData)
  );

  gpio_irq_datapath #(.SYNC_STAGES(2)) dp_i (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .strobes(strobes),
    .detEnQ(detEnQ), .maskQ(maskQ), .pendingQ(pendingQ),
    .senseFlat(senseFlat), .irqLow(irqLow), .irqHigh(irqHigh)
  );
endmodule

// File: tb/gpio_irq_top_tb.sv
module gpio_irq_top_tb_top;
  logic clk = 1'b0;
  logic rstN;
  logic [7:0] regAddr;
  logic regWrEn;
  logic [31:0] regWrData, regRdData, pinIn;
  logic irqLow, irqHigh;
  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_irq_top dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .pinIn(pinIn),
    .irqLow(irqLow), .irqHigh(irqHigh)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic cycles(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic setSense(int pin, logic [3:0] code);
    logic [31:0] v;
    logic [7:0] a;
    a = 8'h40 + 8'((pin / 8) * 4);
    rd(a, v);
    v[(pin % 8) * 4 +: 4] = code;
    wr(a, v);
  endtask

  // Configure a pin with its input at an inactive start level, then enable it
  task automatic prep(int pin, logic [3:0] code, logic startLvl);
    pinIn[pin] = startLvl;
    setSense(pin, code);
    cycles(3);
    wr(8'h28, 32'hFFFF_FFFF);
    wr(8'h14, 32'h1 << pin);
  endtask

  task automatic tidy();
    wr(8'h14, 32'h0);
    wr(8'h28, 32'hFFFF_FFFF);
  endtask

  task automatic rawBit(int pin, output logic b);
    logic [31:0] v;
    rd(8'h20, v);
    b = v[pin];
  endtask

  task automatic testReset();
    logic [31:0] v;
    rd(8'h1C, v); check("R1 mask", v, 32'hFFFF_FFFF);
    rd(8'h14, v); check("R1 detEn", v, 32'h0);
    rd(8'h4C, v); check("R1 sense", v, 32'h0);
    rd(8'h20, v); check("R1 raw", v, 32'h0);
    check("R1 irq", {30'h0, irqHigh, irqLow}, 32'h0);
  endtask

  task automatic testRising();
    logic b;
    prep(4, 4'd0, 1'b0);
    pinIn[4] = 1'b1;
    cycles(2); rawBit(4, b); check("R9 before third edge", 32'(b), 32'h0);
    cycles(1); rawBit(4, b); check("R9 R8 rising", 32'(b), 32'h1);
    wr(8'h28, 32'h10);
    cycles(2); rawBit(4, b); check("R10 edge stays clear", 32'(b), 32'h0);
    pinIn[4] = 1'b0;
    tidy();
  endtask

  task automatic testFalling();
    logic b;
    prep(9, 4'd1, 1'b1);
    pinIn[9] = 1'b0;
    cycles(3); rawBit(9, b); check("R8 falling", 32'(b), 32'h1);
    tidy();
  endtask

  task automatic testBoth();
    logic b;
    prep(12, 4'd4, 1'b1);
    pinIn[12] = 1'b0;
    cycles(3); rawBit(12, b); check("R8 both fall", 32'(b), 32'h1);
    wr(8'h28, 32'h1000);
    pinIn[12] = 1'b1;
    cycles(3); rawBit(12, b); check("R8 both rise", 32'(b), 32'h1);
    pinIn[12] = 1'b0;
    cycles(3);
    tidy();
  endtask

  task automatic testLowLevel();
    logic b;
    prep(17, 4'd3, 1'b1);
    pinIn[17] = 1'b0;
    cycles(3); rawBit(17, b); check("R8 low level", 32'(b), 32'h1);
    pinIn[17] = 1'b1;
    cycles(3);
    tidy();
  endtask

  task automatic testLevelReset();
    logic b;
    prep(5, 4'd2, 1'b0);
    pinIn[5] = 1'b1;
    cycles(3); rawBit(5, b); check("R8 high level", 32'(b), 32'h1);
    wr(8'h28, 32'h20);
    rawBit(5, b); check("R10 cleared", 32'(b), 32'h0);
    cycles(1); rawBit(5, b); check("R10 level re-set", 32'(b), 32'h1);
    pinIn[5] = 1'b0;
    cycles(3);
    tidy();
  endtask

  task automatic testNoMode();
    logic b;
    prep(6, 4'd5, 1'b0);
    pinIn[6] = 1'b1; cycles(3);
    pinIn[6] = 1'b0; cycles(3);
    rawBit(6, b); check("R8 code 5 inert", 32'(b), 32'h0);
    tidy();
  endtask

  task automatic testAsyncFlag();
    logic b;
    logic [31:0] v;
    prep(7, 4'd8, 1'b0);
    rd(8'h40, v); check("R7 field readback", 32'(v[31:28]), 32'h8);
    pinIn[7] = 1'b1;
    cycles(3); rawBit(7, b); check("R8 flag keeps rising", 32'(b), 32'h1);
    pinIn[7] = 1'b0;
    cycles(3);
    tidy();
  endtask

  task automatic testDisabled();
    logic b;
    logic [31:0] v;
    prep(10, 4'd0, 1'b0);
    wr(8'h14, 32'h0000_0800);
    rd(8'h14, v); check("R2 detEn readback", v, 32'h0000_0800);
    pinIn[10] = 1'b1;
    cycles(3); rawBit(10, b); check("R2 disabled pin", 32'(b), 32'h0);
    pinIn[10] = 1'b0;
    cycles(3);
    tidy();
  endtask

  task automatic testMaskIrq();
    logic [31:0] v;
    pinIn[2] = 1'b0; pinIn[20] = 1'b0;
    setSense(2, 4'd0); setSense(20, 4'd0);
    cycles(3);
    wr(8'h28, 32'hFFFF_FFFF);
    wr(8'h14, 32'h0010_0004);
    pinIn[2] = 1'b1; pinIn[20] = 1'b1;
    cycles(3);
    rd(8'h20, v); check("R5 raw", v, 32'h0010_0004);
    rd(8'h24, v); check("R5 masked status", v, 32'h0);
    check("R12 all masked", {30'h0, irqHigh, irqLow}, 32'h0);
    wr(8'h18, 32'h4);
    rd(8'h1C, v); check("R3 unmask one", v, 32'hFFFF_FFFB);
    rd(8'h24, v); check("R5 status", v, 32'h4);
    check("R12 low only", {30'h0, irqHigh, irqLow}, 32'h1);
    wr(8'h18, 32'h0010_0000);
    check("R12 both", {30'h0, irqHigh, irqLow}, 32'h3);
    wr(8'h1C, 32'h4);
    rd(8'h1C, v); check("R4 mask one", v, 32'hFFEF_FFFF);
    check("R12 high only", {30'h0, irqHigh, irqLow}, 32'h2);
    wr(8'h28, 32'h0010_0000);
    rd(8'h20, v); check("R6 zeros keep", v, 32'h4);
    check("R12 after clear", {30'h0, irqHigh, irqLow}, 32'h0);
    wr(8'h1C, 32'hFFFF_FFFF);
    pinIn[2] = 1'b0; pinIn[20] = 1'b0;
    cycles(3);
    tidy();
  endtask

  task automatic testModeChange();
    logic b;
    prep(3, 4'd0, 1'b0);
    pinIn[3] = 1'b1;
    cycles(3); rawBit(3, b); check("R11 old event", 32'(b), 32'h1);
    setSense(3, 4'd1);
    wr(8'h28, 32'h8);
    cycles(4); rawBit(3, b); check("R11 removed", 32'(b), 32'h0);
    pinIn[3] = 1'b0;
    cycles(3);
    tidy();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; regAddr = '0; regWrEn = 1'b0; regWrData = '0; pinIn = '0;
    cycles(3);
    rstN = 1'b1;
    cycles(1);
    testReset();
    testRising();
    testFalling();
    testBoth();
    testLowLevel();
    testLevelReset();
    testNoMode();
    testAsyncFlag();
    testDisabled();
    testMaskIrq();
    testModeChange();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule